// File: doc/BRIEF.md
# Transmit checksum offload inserter

This block sits in a transmit path in front of a MAC. Each packet reaches it as a byte stream. The stream opens with three 32-bit words that describe the packet: a first command word, a second command word and a checksum control word. The frame bytes follow. The block consumes the three words and stores the whole frame. When the packet asks for offload, the block also computes a 16-bit sum with end-around carry, running from a chosen start offset to the last frame byte. When the frame is complete, the block streams it out and substitutes the sum at a chosen byte offset.

Offload runs only when three conditions hold together: a first-segment flag in the first command word, a checksum-request flag in the second command word, and the block-level enable input. If any of them is clear, the frame leaves unchanged. The offsets are checked against the frame length. An offset that lands in the 14-byte MAC header or in the final 4 bytes raises an error flag on the outgoing packet, and that packet is forwarded untouched.

Top module: `tx_csum_ins`

## Requirements
- R1: The first 12 bytes accepted for a packet are the descriptor and never appear on the output. The words come in the order first command, second command, control, each sent least significant byte first.
- R2: Checksum work is done only when bit 13 of the first command word, bit 14 of the second command word and `cs_enable` are all 1. `cs_enable` is sampled when the last descriptor byte is accepted.
- R3: When bit 14 of the second command word is 0, the frame is forwarded byte for byte and `out_err` stays low, whatever `cs_enable` and the offsets are.
- R4: Control word bits 11:0 give the byte offset within the frame where summing starts. Summing continues up to and including the final frame byte.
- R5: Control word bits 27:16 give the insertion offset. The sum's low byte replaces the frame byte at that offset and its high byte replaces the next one. All other bytes are unchanged.
- R6: The sum adds 16-bit values with end-around carry. Each value takes the byte at an even distance from the start as its low half and the following byte as its high half. An odd final byte is paired with a zero high half. The result is inserted without complementing, and it is zero only when every summed byte is zero.
- R7: With offload requested, the packet is forwarded unmodified with `out_err` high on every output byte if the start offset is below 14 or above L-5, or if the insertion offset is below 14 or above L-6, where L is the frame length in bytes.
- R8: Frames of up to DEPTH bytes are fully stored before output begins. After the last input byte is accepted, `in_ready` stays low until the last output byte is accepted. While `out_valid` is high and `out_ready` is low, the output holds its values.
- R9: The output carries exactly L bytes per packet, and `out_last` is high on the final one only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_enable | input | 1 | Block-level offload enable |
| in_data | input | 8 | Input byte: descriptor, then frame |
| in_valid | input | 1 | Input byte present |
| in_last | input | 1 | Marks the final frame byte |
| in_ready | output | 1 | Block accepts an input byte |
| out_data | output | 8 | Output frame byte |
| out_valid | output | 1 | Output byte present |
| out_last | output | 1 | Marks the final output byte |
| out_err | output | 1 | Offset error for the packet being output |
| out_ready | input | 1 | Downstream accepts an output byte |

## Verification
The assertions assume that every packet brings exactly 12 descriptor bytes before any byte marked last, and that no frame is longer than the buffer depth. The stimulus keeps to both: each packet is built as three words followed by a frame of 18 to 300 bytes, and the last marker is set only on the final frame byte. Random offsets are mostly drawn inside the legal window, with a minority drawn across the whole frame to reach the error path. Directed packets cover the disabled flags, the window edges, odd lengths and all-zero and all-ones data.

// File: rtl/tco_pkg.sv
package tco_pkg;

    localparam int HDR_BYTES   = 12;
    localparam int OFS_W       = 12;
    localparam int MAC_HDR     = 14;
    localparam int TAIL_BYTES  = 4;
    localparam int FS_BIT      = 13;
    localparam int CK_BIT      = 14;
    localparam int FS_BYTE     = FS_BIT / 8;
    localparam int CK_BYTE     = 4 + CK_BIT / 8;
    localparam int CTRL_BYTE   = 8;

    typedef enum logic [1:0] {
        ST_HDR,
        ST_DATA,
        ST_CHK,
        ST_OUT
    } tco_state_e;

    typedef struct packed {
        logic [OFS_W-1:0] start;
        logic [OFS_W-1:0] loc;
        logic             want;
    } pkt_ctl_t;

    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'd0, s[16]};
    endfunction

endpackage

// File: rtl/tco_buf.sv
module tco_buf #(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tco_sum.sv
module tco_sum
    import tco_pkg::*;
#(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en_byte,
    input  logic [CW-1:0] idx,
    input  logic [CW-1:0] start,
    input  logic [7:0]    data,
    output logic [15:0]   sum
);
    logic        in_range;
    logic        high_half;
    logic [15:0] term;

    assign in_range  = idx >= start;
    assign high_half = idx[0] ^ start[0];
    assign term      = high_half ? {data, 8'h00} : {8'h00, data};

    always_ff @(posedge clk) begin
        if (rst || clr)
            sum <= '0;
        else if (en_byte && in_range)
            sum <= oc_add(sum, term);
    end

    a_r6_sum_holds: assert property (@(posedge clk) disable iff (rst)
        (!en_byte && !clr) |=> $stable(sum));

    a_r6_sum_cleared: assert property (@(posedge clk) disable iff (rst)
        clr |=> (sum == 16'h0000));
endmodule

// File: rtl/tx_csum_ins.sv
module tx_csum_ins
    import tco_pkg::*;
#(
    parameter int DEPTH = 2048
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_enable,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    output logic       in_ready,
    output logic [7:0] out_data,
    output logic       out_valid,
    output logic       out_last,
    output logic       out_err,
    input  logic       out_ready
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;
    localparam int CW = ((LW > OFS_W) ? LW : OFS_W) + 1;

    tco_state_e       st;
    logic [3:0]       hcnt;
    pkt_ctl_t         ctl;
    logic             do_cs;
    logic             apply_q;
    logic             err_q;
    logic [LW-1:0]    widx;
    logic [LW-1:0]    len_q;
    logic [LW-1:0]    rd_ptr;
    logic [15:0]      sum;
    logic [7:0]       rdata;
    logic             acc;
    logic             wr_en;
    logic             last_hdr;
    logic [CW-1:0]    start_x;
    logic [CW-1:0]    loc_x;
    logic [CW-1:0]    len_x;
    logic [CW-1:0]    rd_x;
    logic             ofs_ok;

    assign in_ready  = (st == ST_HDR) || (st == ST_DATA);
    assign acc       = in_valid && in_ready;
    assign wr_en     = acc && (st == ST_DATA);
    assign last_hdr  = acc && (st == ST_HDR) && (hcnt == 4'(HDR_BYTES - 1));

    assign start_x = CW'(ctl.start);
    assign loc_x   = CW'(ctl.loc);
    assign len_x   = CW'(len_q);
    assign rd_x    = CW'(rd_ptr);

    assign ofs_ok = (start_x >= CW'(MAC_HDR)) &&
                    (start_x + CW'(TAIL_BYTES + 1) <= len_x) &&
                    (loc_x >= CW'(MAC_HDR)) &&
                    (loc_x + CW'(TAIL_BYTES + 2) <= len_x);

    tco_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
        .clk   (clk),
        .we    (wr_en),
        .waddr (widx[AW-1:0]),
        .wdata (in_data),
        .raddr (rd_ptr[AW-1:0]),
        .rdata (rdata)
    );

    tco_sum #(.CW(CW)) u_sum (
        .clk     (clk),
        .rst     (rst),
        .clr     (last_hdr),
        .en_byte (wr_en && do_cs),
        .idx     (CW'(widx)),
        .start   (start_x),
        .data    (in_data),
        .sum     (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_HDR;
            hcnt    <= '0;
            ctl     <= '0;
            do_cs   <= 1'b0;
            apply_q <= 1'b0;
            err_q   <= 1'b0;
            widx    <= '0;
            len_q   <= '0;
            rd_ptr  <= '0;
        end else begin
            case (st)
                ST_HDR: if (acc) begin
                    hcnt <= hcnt + 4'd1;
                    if (hcnt == 4'(FS_BYTE))        ctl.want <= in_data[FS_BIT % 8];
                    if (hcnt == 4'(CK_BYTE))        ctl.want <= ctl.want & in_data[CK_BIT % 8];
                    if (hcnt == 4'(CTRL_BYTE))      ctl.start[7:0] <= in_data;
                    if (hcnt == 4'(CTRL_BYTE + 1))  ctl.start[OFS_W-1:8] <= in_data[OFS_W-9:0];
                    if (hcnt == 4'(CTRL_BYTE + 2))  ctl.loc[7:0] <= in_data;
                    if (last_hdr) begin
                        ctl.loc[OFS_W-1:8] <= in_data[OFS_W-9:0];
                        do_cs <= ctl.want & cs_enable;
                        widx  <= '0;
                        st    <= ST_DATA;
                    end
                end
                ST_DATA: if (acc) begin
                    widx <= widx + LW'(1);
                    if (in_last) begin
                        len_q <= widx + LW'(1);
                        st    <= ST_CHK;
                    end
                end
                ST_CHK: begin
                    apply_q <= do_cs && ofs_ok;
                    err_q   <= do_cs && !ofs_ok;
                    rd_ptr  <= '0;
                    st      <= ST_OUT;
                end
                default: if (out_ready) begin
                    rd_ptr <= rd_ptr + LW'(1);
                    if (out_last) begin
                        st   <= ST_HDR;
                        hcnt <= '0;
                    end
                end
            endcase
        end
    end

    always_comb begin
        out_data = rdata;
        if (apply_q && (rd_x == loc_x))
            out_data = sum[7:0];
        else if (apply_q && (rd_x == loc_x + CW'(1)))
            out_data = sum[15:8];
    end

    assign out_valid = (st == ST_OUT);
    assign out_last  = out_valid && (rd_ptr == len_q - LW'(1));
    assign out_err   = out_valid && err_q;

    a_r1_no_last_in_hdr: assert property (@(posedge clk) disable iff (rst)
        (in_valid && st == ST_HDR) |-> !in_last);

    a_r8_fits_buffer: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (widx < LW'(DEPTH)));

    a_r8_ready_drops: assert property (@(posedge clk) disable iff (rst)
        (acc && in_last) |=> !in_ready);

    a_r8_hold_output: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last) && $stable(out_err)));

    a_r9_last_ends_packet: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !out_valid);

    a_r6_sum_frozen_out: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> $stable(sum));

    a_r7_err_only_if_offload: assert property (@(posedge clk) disable iff (rst)
        out_err |-> !apply_q);
endmodule

// File: tb/tb_tx_csum_ins.sv
module tb_tx_csum_ins;

    logic       clk = 1'b0;
    logic       rst;
    logic       cs_enable;
    logic [7:0] in_data;
    logic       in_valid;
    logic       in_last;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_last;
    logic       out_err;
    logic       out_ready;

    always #2 clk = ~clk;

    tx_csum_ins #(.DEPTH(2048)) dut (
        .clk(clk), .rst(rst), .cs_enable(cs_enable),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
        .out_err(out_err), .out_ready(out_ready)
    );

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] frm[$];
    logic [7:0] expq[$];
    logic [7:0] got[$];
    bit exp_err;
    bit got_err;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model(input logic [31:0] a, input logic [31:0] b, input int st,
                         input int lc, input bit en);
        int len;
        bit do_cs;
        bit ok;
        logic [16:0] t;
        logic [15:0] s;
        logic [15:0] w;
        len   = frm.size();
        do_cs = en && a[13] && b[14];
        ok    = (st >= 14) && (st + 5 <= len) && (lc >= 14) && (lc + 6 <= len);
        exp_err = do_cs && !ok;
        expq = frm;
        if (do_cs && ok) begin
            s = 16'h0;
            for (int i = st; i < len; i += 2) begin
                w = {((i + 1 < len) ? frm[i+1] : 8'h00), frm[i]};
                t = {1'b0, s} + {1'b0, w};
                s = t[15:0] + {15'd0, t[16]};
            end
            expq[lc]   = s[7:0];
            expq[lc+1] = s[15:8];
        end
    endtask

    task automatic send_byte(input logic [7:0] d, input logic l);
        if ($urandom_range(0, 3) == 0) begin
            in_valid = 1'b0;
            @(negedge clk);
        end
        in_valid = 1'b1;
        in_data  = d;
        in_last  = l;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic recv();
        bit done;
        done = 0;
        got.delete();
        got_err = 0;
        while (!done) begin
            @(negedge clk);
            out_ready = ($urandom_range(0, 3) != 0);
            if (out_valid && out_ready) begin
                got.push_back(out_data);
                got_err |= out_err;
                if (out_last || got.size() > 4000) done = 1;
            end
        end
    endtask

    task automatic run_pkt(input logic [31:0] a, input logic [31:0] b, input int st,
                           input int lc, input bit en, input int len, input int fill,
                           input string tag);
        logic [31:0] c;
        logic [31:0] words [3];
        int mism;
        int first_bad;
        frm.delete();
        for (int i = 0; i < len; i++)
            frm.push_back(fill == 1 ? 8'h00 : fill == 2 ? 8'hff : 8'($urandom));
        c = {4'h0, 12'(lc), 4'h0, 12'(st)};
        words[0] = a; words[1] = b; words[2] = c;
        model(a, b, st, lc, en);
        cs_enable = en;
        fork
            begin
                for (int w = 0; w < 3; w++)
                    for (int k = 0; k < 4; k++)
                        send_byte(words[w][8*k +: 8], 1'b0);
                for (int i = 0; i < len; i++)
                    send_byte(frm[i], (i == len - 1));
                chk(in_ready == 1'b0, {tag, " R8 in_ready low after last byte"}, in_ready, 0);
            end
            recv();
        join
        chk(got.size() == len, {tag, " R1 R9 output length"}, got.size(), len);
        mism = 0;
        first_bad = -1;
        for (int i = 0; i < len && i < got.size(); i++)
            if (got[i] !== expq[i]) begin
                mism++;
                if (first_bad < 0) first_bad = i;
            end
        if (first_bad < 0)
            chk(mism == 0, {tag, " R4 R5 R6 data"}, 0, 0);
        else
            chk(1'b0, {tag, " R4 R5 R6 data"}, got[first_bad], expq[first_bad]);
        chk(got_err == exp_err, {tag, " R7 out_err"}, got_err, exp_err);
    endtask

    localparam logic [31:0] A_FS = 32'h0000_2000;
    localparam logic [31:0] B_CK = 32'h0000_4000;

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R8 actual=%0h expected=%0h", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        in_valid = 1'b0; in_last = 1'b0; in_data = 8'h00;
        out_ready = 1'b0; cs_enable = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R8 reset state", {in_ready, out_valid}, 2'b10);

        run_pkt(A_FS, B_CK, 20, 30, 1'b0, 64, 0, "R2 enable low");
        run_pkt(A_FS, 32'h0, 2, 3, 1'b1, 64, 0, "R3 ck clear bad offsets");
        run_pkt(A_FS, 32'hffff_bfff, 20, 30, 1'b1, 64, 0, "R3 ck clear other bits set");
        run_pkt(32'hffff_dfff, B_CK, 20, 30, 1'b1, 64, 0, "R2 fs clear");
        run_pkt(A_FS, B_CK, 14, 14, 1'b1, 64, 0, "R4 R5 low edges");
        run_pkt(A_FS, B_CK, 96, 95, 1'b1, 101, 0, "R6 odd length start L-5 loc L-6");
        run_pkt(A_FS, B_CK, 15, 14, 1'b1, 20, 0, "R4 odd start short frame");
        run_pkt(A_FS, B_CK, 13, 20, 1'b1, 64, 0, "R7 start in mac header");
        run_pkt(A_FS, B_CK, 20, 59, 1'b1, 64, 0, "R7 loc in tail");
        run_pkt(A_FS, B_CK, 60, 20, 1'b1, 64, 0, "R7 start in tail");
        run_pkt(A_FS, B_CK, 14, 12, 1'b1, 64, 0, "R7 loc in mac header");
        run_pkt(A_FS, B_CK, 20, 14, 1'b1, 18, 0, "R7 frame too short");
        run_pkt(A_FS, B_CK, 14, 40, 1'b1, 80, 1, "R6 all zero");
        run_pkt(A_FS, B_CK, 14, 40, 1'b1, 81, 2, "R6 all ones carry");

        for (int p = 0; p < 40; p++) begin
            int len;
            int st;
            int lc;
            bit en;
            logic [31:0] a;
            logic [31:0] b;
            len = $urandom_range(20, 300);
            en  = ($urandom_range(0, 7) != 0);
            a   = $urandom;
            b   = $urandom;
            a[13] = ($urandom_range(0, 7) != 0);
            b[14] = ($urandom_range(0, 7) != 0);
            if ($urandom_range(0, 5) == 0) begin
                st = $urandom_range(0, len + 8);
                lc = $urandom_range(0, len + 8);
            end else begin
                st = $urandom_range(14, len - 5);
                lc = $urandom_range(14, len - 6);
            end
            run_pkt(a, b, st, lc, en, len, 0, "R2 R4 R5 R6 R7 random");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule